// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block rotates a two-dimensional vector by an angle, one sample per clock, using the CORDIC shift-and-add method in rotation mode. Each input sample has three parts: a signed X coordinate, a signed Y coordinate and an unsigned angle word. The angle word covers one full turn, and its LSB weighs 1/65536 of a turn. The two top angle bits first rotate the vector by a whole multiple of 90 degrees. The remaining fourteen bits then become a residual angle, and twelve registered micro-rotation stages drive that residual towards zero.

X and Y are widened by two copies of their sign bit at the entry. This gives the growth of the vector room inside the pipeline without wrap. The outputs come straight from the last stage's registers. They carry the uncorrected CORDIC gain of about 1.6468. The leftover residual angle is also brought out, so a user can judge or refine the result.

The block is meant for a streaming datapath such as a mixer, a phase rotator or a coordinate converter. In that setting the fixed latency is known to the surrounding logic, and gain is compensated elsewhere.

Top module: `cordic_rotator`

## Requirements
- R1: While rst_n is low, every pipeline register is cleared at once, with no clock needed, so x_out, y_out and z_out all read zero.
- R2: A sample applied before rising edge k appears on the outputs just after edge k+12, which is a latency of 13 registers. A new sample may enter on every edge, and a sample never shows up a cycle early.
- R3: Angle bits [15:14] choose a coarse pre-rotation. 00 leaves (X,Y) as they are. 01 gives (-Y,X). 10 gives (-X,-Y). 11 gives (Y,-X). Bits [13:0] enter the pipeline as a non-negative residual, and the pre-rotation keeps X*X+Y*Y unchanged.
- R4: Treat x_out, y_out and z_out as two's complement. Let phi = 2*pi*(z_in - z_out)/65536 and K = product over i=0..11 of sqrt(1+2^(-2i)). Then each output component equals K times the input vector rotated by phi, within 72 LSB.
- R5: The signed residual z_out never exceeds 22 LSB in magnitude. Inside each stage, the residual magnitude after the stage never exceeds the larger of its magnitude before the stage and that stage's constant.
- R6: While en is low, no register changes, so all three outputs hold their values whatever the inputs do.
- R7: x_out and y_out are 18 bits wide, with two guard bits. Full-scale inputs such as (-32768,-32768) at any angle give correctly signed results without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| en | input | 1 | Clock enable for every pipeline register |
| x_in | input | 16 | Signed X coordinate |
| y_in | input | 16 | Signed Y coordinate |
| z_in | input | 16 | Unsigned rotation angle, full turn = 65536 |
| x_out | output | 18 | Signed rotated X, gain K included |
| y_out | output | 18 | Signed rotated Y, gain K included |
| z_out | output | 15 | Signed residual angle left after the last stage |

## Verification
Every stage register feeds the outputs exactly once. A corrupted X, Y or residual value in stage k therefore reaches the ports 12-k cycles later, as a vector off by far more than the 72 LSB tolerance, or as a residual outside the 22 LSB bound. A wrong quadrant choice or a lost guard bit shows up in the first sample that uses it: a sign flip or a swap of the two components, 13 cycles after entry. A stage that ignores the enable, or a wrong stage count, shifts the whole stream by a cycle. Every later sample then mismatches at once.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

  // Sign-extension guard bits carried on X and Y through the pipeline.
  localparam int GUARD_BITS = 2;

  typedef enum logic [1:0] {
    QUAD_0   = 2'b00,
    QUAD_90  = 2'b01,
    QUAD_180 = 2'b10,
    QUAD_270 = 2'b11
  } quad_e;

  // atan(2^-idx) expressed on a 16-bit full-turn scale, rounded, then
  // rescaled to an angle word of zw bits.
  function automatic int atan_scaled(input int idx, input int zw);
    int base;
    case (idx)
      0:  base = 8192;
      1:  base = 4836;
      2:  base = 2555;
      3:  base = 1297;
      4:  base = 651;
      5:  base = 326;
      6:  base = 163;
      7:  base = 81;
      8:  base = 41;
      9:  base = 20;
      10: base = 10;
      11: base = 5;
      12: base = 3;
      13: base = 1;
      14: base = 1;
      default: base = 0;
    endcase
    if (zw >= 16) return base <<< (zw - 16);
    return (base + (1 <<< (15 - zw))) >>> (16 - zw);
  endfunction

endpackage

// File: rtl/cordic_quadrant.sv
module cordic_quadrant
  import cordic_rot_pkg::*;
#(
  parameter int XY_W = 16,
  parameter int Z_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [XY_W-1:0]               x_in,
  input  logic [XY_W-1:0]               y_in,
  input  logic [Z_W-1:0]                z_in,
  output logic signed [XY_W+GUARD_BITS-1:0] x_q,
  output logic signed [XY_W+GUARD_BITS-1:0] y_q,
  output logic signed [Z_W-2:0]         z_q
);

  localparam int W   = XY_W + GUARD_BITS;
  localparam int ZRW = Z_W - 1;
  localparam int NW  = 2 * W + 2;

  logic signed [W-1:0]   x_ext, y_ext, x_nx, y_nx;
  logic signed [ZRW-1:0] z_nx;
  quad_e                 quad;

  // Next-state: widen, pick quadrant, keep the low angle bits as residual.
  always_comb begin
    x_ext = {{GUARD_BITS{x_in[XY_W-1]}}, x_in};
    y_ext = {{GUARD_BITS{y_in[XY_W-1]}}, y_in};
    quad  = quad_e'(z_in[Z_W-1 -: 2]);
    z_nx  = {1'b0, z_in[Z_W-3:0]};
    case (quad)
      QUAD_0:   begin x_nx = x_ext;  y_nx = y_ext;  end
      QUAD_90:  begin x_nx = -y_ext; y_nx = x_ext;  end
      QUAD_180: begin x_nx = -x_ext; y_nx = -y_ext; end
      default:  begin x_nx = y_ext;  y_nx = -x_ext; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (en) begin
      x_q <= x_nx;
      y_q <= y_nx;
      z_q <= z_nx;
    end
  end

  // Squared length before and after the coarse rotation.
  logic signed [NW-1:0] norm_in, norm_q;
  always_comb begin
    norm_in = NW'(x_ext) * NW'(x_ext) + NW'(y_ext) * NW'(y_ext);
    norm_q  = NW'(x_q) * NW'(x_q) + NW'(y_q) * NW'(y_q);
  end

  // R3
  prerot_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> norm_q == $past(norm_in));

endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
  parameter int W     = 18,
  parameter int ZW    = 15,
  parameter int SHIFT = 0,
  parameter int ATAN  = 8192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  y_in,
  input  logic signed [ZW-1:0] z_in,
  output logic signed [W-1:0]  x_q,
  output logic signed [W-1:0]  y_q,
  output logic signed [ZW-1:0] z_q
);

  localparam logic signed [ZW-1:0] ATAN_C = ZW'(ATAN);

  logic signed [W-1:0]  x_sh, y_sh, x_nx, y_nx;
  logic signed [ZW-1:0] z_nx;

  // Next-state: the sign of the residual picks the turning direction.
  always_comb begin
    x_sh = x_in >>> SHIFT;
    y_sh = y_in >>> SHIFT;
    if (!z_in[ZW-1]) begin
      x_nx = x_in - y_sh;
      y_nx = y_in + x_sh;
      z_nx = z_in - ATAN_C;
    end else begin
      x_nx = x_in + y_sh;
      y_nx = y_in - x_sh;
      z_nx = z_in + ATAN_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (en) begin
      x_q <= x_nx;
      y_q <= y_nx;
      z_q <= z_nx;
    end
  end

  logic [ZW-1:0] zin_mag, zq_mag, zlim;
  always_comb begin
    zin_mag = z_in[ZW-1] ? -z_in : z_in;
    zq_mag  = z_q[ZW-1]  ? -z_q  : z_q;
    zlim    = (zin_mag > ATAN_C) ? zin_mag : ATAN_C;
  end

  // R5
  angle_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> zq_mag <= $past(zlim));

  // R6
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(x_q) && $stable(y_q) && $stable(z_q));

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
  import cordic_rot_pkg::*;
#(
  parameter int XY_W   = 16,
  parameter int Z_W    = 16,
  parameter int STAGES = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [XY_W-1:0]                x_in,
  input  logic [XY_W-1:0]                y_in,
  input  logic [Z_W-1:0]                 z_in,
  output logic [XY_W+GUARD_BITS-1:0]     x_out,
  output logic [XY_W+GUARD_BITS-1:0]     y_out,
  output logic [Z_W-2:0]                 z_out
);

  localparam int W         = XY_W + GUARD_BITS;
  localparam int ZRW       = Z_W - 1;
  localparam int RES_BOUND = 2 * atan_scaled(STAGES - 1, Z_W) + STAGES;

  logic signed [W-1:0]   xs [0:STAGES];
  logic signed [W-1:0]   ys [0:STAGES];
  logic signed [ZRW-1:0] zs [0:STAGES];

  cordic_quadrant #(.XY_W(XY_W), .Z_W(Z_W)) u_quad (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .x_q(xs[0]), .y_q(ys[0]), .z_q(zs[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cordic_microrot #(
      .W(W), .ZW(ZRW), .SHIFT(g), .ATAN(atan_scaled(g, Z_W))
    ) u_rot (
      .clk(clk), .rst_n(rst_n), .en(en),
      .x_in(xs[g]), .y_in(ys[g]), .z_in(zs[g]),
      .x_q(xs[g+1]), .y_q(ys[g+1]), .z_q(zs[g+1])
    );
  end

  assign x_out = xs[STAGES];
  assign y_out = ys[STAGES];
  assign z_out = zs[STAGES];

  int z_res;
  assign z_res = int'($signed(z_out));

  // R5
  residual_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_res <= RES_BOUND) && (z_res >= -RES_BOUND));

endmodule

// File: tb/sim_cordic_rotator.sv
`timescale 1ns/1ps
module sim_cordic_rotator;

  localparam int  STAGES    = 12;
  localparam int  LAT       = STAGES + 1;
  localparam int  NVEC      = 5;
  localparam int  NANG      = 264;
  localparam int  NSAMP     = NVEC * NANG;
  localparam int  RES_BOUND = 22;
  localparam real TOL       = 72.0;
  localparam real TWO_PI    = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] x_in = '0, y_in = '0, z_in = '0;
  logic [17:0] x_out, y_out;
  logic [14:0] z_out;

  int  checks = 0;
  int  errors = 0;
  int  sx [NSAMP];
  int  sy [NSAMP];
  int  sz [NSAMP];
  int  stag [NSAMP];
  real gain;

  always #10 clk = ~clk;

  cordic_rotator #(.XY_W(16), .Z_W(16), .STAGES(STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  task automatic check_exact(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input real act, input real exp);
    real d;
    checks++;
    d = act - exp;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      errors++;
      $display("FAIL %s: actual=%0f expected=%0f", req, act, exp);
    end
  endtask

  task automatic check_bound(input string req, input int act, input int lim);
    checks++;
    if (act > lim || act < -lim) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=within +/-%0d", req, act, lim);
    end
  endtask

  // Compare the outputs with the ideal rotation of sample (vx,vy,vz).
  task automatic check_vector(input string req, input int vx, input int vy, input int vz);
    real zr, phi, ex, ey;
    zr  = $signed(z_out);
    phi = (real'(vz) - zr) * TWO_PI / 65536.0;
    ex  = gain * (real'(vx) * $cos(phi) - real'(vy) * $sin(phi));
    ey  = gain * (real'(vx) * $sin(phi) + real'(vy) * $cos(phi));
    check_near(req, real'($signed(x_out)), ex);
    check_near(req, real'($signed(y_out)), ey);
    check_bound("R5", int'($signed(z_out)), RES_BOUND);
  endtask

  function automatic int vec_x(input int v);
    case (v) 0: return 20000; 1: return 0; 2: return -32768; 3: return 12345; default: return 32767; endcase
  endfunction

  function automatic int vec_y(input int v);
    case (v) 0: return 0; 1: return -15000; 2: return -32768; 3: return -23456; default: return 32767; endcase
  endfunction

  function automatic int edge_angle(input int e);
    case (e)
      0: return 0;     1: return 16383; 2: return 16384; 3: return 32767;
      4: return 32768; 5: return 49151; 6: return 49152; default: return 65535;
    endcase
  endfunction

  initial begin
    gain = 1.0;
    for (int i = 0; i < STAGES; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    for (int v = 0; v < NVEC; v++) begin
      for (int a = 0; a < NANG; a++) begin
        int s;
        s = v * NANG + a;
        sx[s] = vec_x(v);
        sy[s] = vec_y(v);
        sz[s] = (a < 256) ? (a * 256 + ((a * 37) & 255)) : edge_angle(a - 256);
        stag[s] = (v == 2) ? 7 : ((a >= 256) ? 3 : 4);
      end
    end

    // R1: outputs zero while reset is held
    repeat (3) @(negedge clk);
    check_exact("R1", longint'(x_out), 0);
    check_exact("R1", longint'(y_out), 0);
    check_exact("R1", longint'(z_out), 0);

    // R2: a single sample after an all-zero history, not early, then present
    rst_n = 1'b1;
    en    = 1'b1;
    x_in  = 16'(20000);
    y_in  = 16'(0);
    z_in  = 16'h4000;
    @(negedge clk);
    x_in = '0;
    z_in = '0;
    for (int t = 1; t <= LAT; t++) begin
      if (t == LAT - 1) begin
        check_exact("R2", longint'($signed(x_out)), 0);
        check_exact("R2", longint'($signed(y_out)), 0);
      end
      if (t == LAT) check_vector("R2", 20000, 0, 16384);
      else @(negedge clk);
    end

    // R2/R3/R4/R7: back-to-back stream over the angle sweep
    for (int t = 0; t < NSAMP + LAT; t++) begin
      if (t >= LAT) begin
        int s;
        s = t - LAT;
        case (stag[s])
          3:       check_vector("R3", sx[s], sy[s], sz[s]);
          7:       check_vector("R7", sx[s], sy[s], sz[s]);
          default: check_vector("R4", sx[s], sy[s], sz[s]);
        endcase
      end
      if (t < NSAMP) begin
        x_in = 16'(sx[t]);
        y_in = 16'(sy[t]);
        z_in = 16'(sz[t]);
      end else begin
        x_in = '0;
        y_in = '0;
        z_in = '0;
      end
      @(negedge clk);
    end

    // R6: fill with one sample, freeze, then change inputs
    x_in = 16'(20000);
    y_in = 16'(5000);
    z_in = 16'h1234;
    repeat (LAT + 1) @(negedge clk);
    en = 1'b0;
    begin
      logic [17:0] hx, hy;
      logic [14:0] hz;
      hx = x_out;
      hy = y_out;
      hz = z_out;
      check_exact("R6", longint'(hx == 0), 0);
      for (int k = 0; k < 20; k++) begin
        x_in = 16'(k * 1111);
        y_in = 16'(-k * 777);
        z_in = 16'(k * 3001);
        @(negedge clk);
        check_exact("R6", longint'(x_out), longint'(hx));
        check_exact("R6", longint'(y_out), longint'(hy));
        check_exact("R6", longint'(z_out), longint'(hz));
      end
    end

    // R1: asynchronous clear mid-run, no clock edge needed
    en = 1'b1;
    repeat (2) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check_exact("R1", longint'(x_out), 0);
    check_exact("R1", longint'(y_out), 0);
    check_exact("R1", longint'(z_out), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 64'd20);
    checks++;
    errors++;
    $display("FAIL R2: actual=timeout expected=run complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule